// File: doc/BRIEF.md
# Chip-Enable Gating With Reset Hold

This block sits between a processor's active-low chip-enable request and a battery-backed memory. It passes the request through only while the supply is good and the reset generator is not asserting reset, so no write can reach the memory during a brownout. The output is registered and follows the request one clock later.

A plain gate would cut an access off in the middle the moment reset arrives. To avoid that, an access that is already driving the memory when reset first asserts is kept alive for a bounded hold window of `HOLD_CYCLES` clocks. The window closes early if the processor releases its request. After any reset episode, a hold window or a manual-reset clear, the gate stays closed until reset is inactive and the processor has raised its request and lowered it again. A manual-reset clear forces the output inactive at once and cancels any hold.

Top module: `ce_hold_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ce_gated_n` is 1 after that edge.
- R2: With `supply_ok`=1, `rst_active`=0 and `mr_clear`=0, a fresh request (`ce_req_n` seen at 1, then 0) drives `ce_gated_n` to 0 one clock after `ce_req_n` is sampled 0, and `ce_gated_n` returns to 1 one clock after `ce_req_n` is sampled 1.
- R3: While `supply_ok`=0 or `rst_active`=1, a request that is not already driving the output never drives `ce_gated_n` to 0.
- R4: When `rst_active` is sampled 1 on the first edge after being sampled 0, and at that edge `ce_gated_n`=0, `ce_req_n`=0 and `mr_clear`=0, `ce_gated_n` stays 0 for exactly `HOLD_CYCLES` clocks counted from that edge, then goes to 1.
- R5: If `ce_req_n` is sampled 1 during the hold window, `ce_gated_n` goes to 1 at the next clock and does not return to 0 while `rst_active` stays 1.
- R6: The hold window is not restarted while `rst_active` stays 1, nor by a later rising edge of `rst_active` while `ce_gated_n` is 1.
- R7: After `rst_active` or `mr_clear` has been sampled 1, `ce_gated_n` stays 1 until `ce_req_n` is sampled 1 with `rst_active`=0 and `mr_clear`=0, even if `ce_req_n` is held 0 throughout.
- R8: When `mr_clear` is sampled 1, `ce_gated_n` is 1 after that edge, whether the block was passing or holding.
- R9: During the hold window `supply_ok` has no effect; the window runs its full length with `supply_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_req_n | input | 1 | Active-low chip-enable request from the processor |
| supply_ok | input | 1 | 1 when the supply is above the reset threshold |
| rst_active | input | 1 | 1 while the reset generator asserts reset |
| mr_clear | input | 1 | 1 for a qualified manual-reset pulse; closes the gate |
| ce_gated_n | output | 1 | Gated active-low chip enable to the memory |

## Verification
The assertions take all inputs as already synchronous to `clk` and stable around each edge, and take `rst_active` as a level whose rising edge marks the start of a reset episode. The bench drives every input one nanosecond after a rising edge and samples the output one nanosecond after the next, so each input is held for a full cycle. The hold length is overridden to a small value so that exact window boundaries and early releases can be counted clock by clock.

// File: rtl/ce_hold_gate_pkg.sv
// Package: shared types for the chip-enable hold gate.
// Assumes nothing beyond IEEE 1800-2017.
package ce_hold_gate_pkg;

    // Source of the current gate output state.
    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,   // output inactive
        GATE_PASS = 2'd1,   // request passed through
        GATE_HOLD = 2'd2    // access kept alive after reset asserted
    } gate_mode_e;

    // Width of a counter that must hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/ceg_rise_detect.sv
// Module: ceg_rise_detect
// Flags the first cycle on which a level input is seen high after being low.
// Assumes the input is synchronous to clk. After reset the previous value is
// taken as high, so a level already high out of reset does not count as a rise.
module ceg_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    // Remember the level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level_in;
    end

    // Rising edge: high now, low one cycle earlier.
    always_comb rise = level_in & ~level_q;

endmodule

// File: rtl/ceg_hold_timer.sv
// Module: ceg_hold_timer
// Counts down the remaining cycles of a hold window. A start loads
// HOLD_CYCLES-1 (the start cycle itself is the first cycle of the window);
// an abort clears the count at once and wins over start.
// Assumes HOLD_CYCLES >= 1.
module ceg_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy
);
    import ce_hold_gate_pkg::*;

    localparam int unsigned CW = cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] remain_q;

    // Load, count down or clear the remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                 remain_q <= '0;
        else if (abort)             remain_q <= '0;
        else if (start)             remain_q <= LOAD_VAL;
        else if (remain_q != '0)    remain_q <= remain_q - 1'b1;
    end

    // Window still open beyond the current cycle.
    always_comb busy = (remain_q != '0);

    AST_HOLD_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R6

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy); // R5

endmodule

// File: rtl/ceg_fresh_lock.sv
// Module: ceg_fresh_lock
// Blocks pass-through until a fresh request is seen. Set by reset activity
// or a manual clear; cleared only when the request is seen inactive while
// neither is present. Comes out of reset set.
module ceg_fresh_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic block_evt,
    input  logic req_n,
    output logic locked
);
    logic lock_q;

    // Track whether a fresh request edge is still required.
    always_ff @(posedge clk) begin
        if (!rst_n)         lock_q <= 1'b1;
        else if (block_evt) lock_q <= 1'b1;
        else if (req_n)     lock_q <= 1'b0;
    end

    always_comb locked = lock_q;

endmodule

// File: rtl/ce_hold_gate.sv
// Module: ce_hold_gate (top)
// Gates an active-low chip enable for a battery-backed memory. Passes a fresh
// request while supply is good and reset inactive; keeps an access already in
// progress alive for HOLD_CYCLES clocks after reset asserts, or until the
// request ends; closes at once on a manual-reset clear. Output is registered.
// Assumes all inputs are synchronous to clk.
module ce_hold_gate #(
    parameter int unsigned HOLD_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_req_n,
    input  logic supply_ok,
    input  logic rst_active,
    input  logic mr_clear,
    output logic ce_gated_n
);
    import ce_hold_gate_pkg::*;

    gate_mode_e mode_q;
    gate_mode_e mode_d;
    logic       rst_rise;
    logic       hold_start;
    logic       hold_busy;
    logic       locked;
    logic       pass_ok;
    logic       access_on;

    ceg_rise_detect u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (rst_active),
        .rise     (rst_rise)
    );

    ceg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (hold_start),
        .abort (mr_clear | ce_req_n),
        .busy  (hold_busy)
    );

    ceg_fresh_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .block_evt (rst_active | mr_clear),
        .req_n     (ce_req_n),
        .locked    (locked)
    );

    // Qualify hold start and plain pass-through from current inputs.
    always_comb begin
        access_on  = (mode_q != GATE_OFF);
        hold_start = rst_rise & access_on & ~ce_req_n & ~mr_clear;
        pass_ok    = ~ce_req_n & supply_ok & ~rst_active & ~locked & ~mr_clear;
    end

    // Choose next gate mode; manual clear has top priority.
    always_comb begin
        if (mr_clear)                             mode_d = GATE_OFF;
        else if (hold_start)                      mode_d = GATE_HOLD;
        else if (hold_busy && !ce_req_n)          mode_d = GATE_HOLD;
        else if (pass_ok)                         mode_d = GATE_PASS;
        else                                      mode_d = GATE_OFF;
    end

    // Register the mode so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= GATE_OFF;
        else        mode_q <= mode_d;
    end

    assign ce_gated_n = (mode_q == GATE_OFF);

    AST_LOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_gated_n |-> $past(!ce_req_n)); // R2

    AST_BLOCKED_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_active || !supply_ok) && ce_gated_n) |=> ce_gated_n); // R3

    AST_HOLD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_rise && !ce_gated_n && !ce_req_n && !mr_clear) |=> !ce_gated_n); // R4

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_req_n |=> ce_gated_n); // R5

    AST_MR_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mr_clear |=> ce_gated_n); // R8

endmodule

// File: tb/sim_ce_hold_gate.sv
// Bench: directed scenarios, one task each, with a 200 MHz clock.
module sim_ce_hold_gate;
    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst_n, ce_req_n, supply_ok, rst_active, mr_clear;
    logic ce_gated_n;
    int   n_checks = 0;
    int   n_errors = 0;

    always #2.5 clk = ~clk;

    ce_hold_gate #(.HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_req_n(ce_req_n), .supply_ok(supply_ok),
        .rst_active(rst_active), .mr_clear(mr_clear), .ce_gated_n(ce_gated_n)
    );

    // One clock: inputs already set are sampled, then output is read 1 ns later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic exp, input string req);
        n_checks++;
        if (ce_gated_n !== exp) begin
            n_errors++;
            $display("FAIL %s: ce_gated_n=%b expected=%b at %0t", req, ce_gated_n, exp, $time);
        end
    endtask

    // Bring the gate into pass state with a fresh request.
    task automatic open_gate();
        rst_active = 0; supply_ok = 1; mr_clear = 0;
        ce_req_n = 1; step();
        ce_req_n = 0; step();
    endtask

    task automatic t_reset();
        rst_n = 0; ce_req_n = 0; supply_ok = 1; rst_active = 0; mr_clear = 0;
        step(); step();
        chk(1'b1, "R1 reset state");
        rst_n = 1; step();
        chk(1'b1, "R7 no pass without fresh request after reset");
    endtask

    task automatic t_pass();
        open_gate();
        chk(1'b0, "R2 fresh request passes");
        ce_req_n = 1; step();
        chk(1'b1, "R2 release follows");
        ce_req_n = 0; step();
        chk(1'b0, "R2 second request passes");
        ce_req_n = 1; step();
    endtask

    task automatic t_blocked();
        supply_ok = 0; ce_req_n = 0; step();
        chk(1'b1, "R3 low supply blocks new request");
        ce_req_n = 1; step();
        supply_ok = 1; rst_active = 1; step();
        ce_req_n = 0; step(); step();
        chk(1'b1, "R3 request during reset blocked");
        rst_active = 0; step();
        chk(1'b1, "R7 request held through reset stays blocked");
        ce_req_n = 1; step();
        ce_req_n = 0; step();
        chk(1'b0, "R7 fresh request after reset passes");
        ce_req_n = 1; step();
    endtask

    task automatic t_hold_full();
        int lows = 0;
        open_gate();
        rst_active = 1;
        for (int i = 0; i < HOLD; i++) begin
            step();
            if (ce_gated_n === 1'b0) lows++;
        end
        n_checks++;
        if (lows != HOLD) begin
            n_errors++;
            $display("FAIL R4 hold low cycles=%0d expected=%0d", lows, HOLD);
        end
        step();
        chk(1'b1, "R4 hold ends after HOLD_CYCLES");
        step(); step();
        chk(1'b1, "R6 no retrigger while reset held");
        rst_active = 0; step();
        rst_active = 1; step();
        chk(1'b1, "R6 later reset edge with output high");
        rst_active = 0; ce_req_n = 1; step();
    endtask

    task automatic t_hold_early();
        open_gate();
        rst_active = 1; step(); step();
        chk(1'b0, "R4 hold active");
        ce_req_n = 1; step();
        chk(1'b1, "R5 release ends hold early");
        ce_req_n = 0; step(); step();
        chk(1'b1, "R5 no reopen while reset held");
        rst_active = 0; ce_req_n = 1; step();
    endtask

    task automatic t_supply_hold();
        int lows = 0;
        open_gate();
        rst_active = 1; supply_ok = 0;
        for (int i = 0; i < HOLD; i++) begin
            step();
            if (ce_gated_n === 1'b0) lows++;
        end
        n_checks++;
        if (lows != HOLD) begin
            n_errors++;
            $display("FAIL R9 hold with low supply cycles=%0d expected=%0d", lows, HOLD);
        end
        rst_active = 0; supply_ok = 1; ce_req_n = 1; step();
    endtask

    task automatic t_manual();
        open_gate();
        mr_clear = 1; step();
        chk(1'b1, "R8 manual clear closes pass");
        mr_clear = 0; step();
        chk(1'b1, "R7 manual clear needs fresh request");
        open_gate();
        rst_active = 1; step();
        mr_clear = 1; step();
        chk(1'b1, "R8 manual clear cancels hold");
        mr_clear = 0; step();
        chk(1'b1, "R8 hold stays cancelled");
        rst_active = 0; ce_req_n = 1; step();
    endtask

    initial begin
        t_reset();
        t_pass();
        t_blocked();
        t_hold_full();
        t_hold_early();
        t_supply_hold();
        t_manual();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule